// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block produces a single serial control line at the bit rate of the 2.048 Mb/s time-division streams. The line carries one bit for each output position of a 256-position frame, and each position is numbered as stream times 32 plus channel. The value sent for a position is the control flag kept for that position in the connection store. External circuitry uses the line to set per-channel hardware such as line drivers or relays. The serial output therefore runs one full channel (eight bit times) ahead of the stream slot it controls. Position 0 goes out in the slot of stream channel 31, bit 7 of the frame before.

The connection store lies outside the block. The block drives an address onto a combinational read port and registers the returned bit onto the serial pin on the next clock edge. A frame pulse, sampled on a rising clock edge, marks that the following cycle is stream slot 0. At that edge the block loads its position counter with the one-channel advance already applied. After that the counter moves one position per clock and wraps after 256, even when no further pulse arrives. Until the first frame pulse after reset, the output stays low.

Top module: `cso_serializer`

## Requirements
- R1: While reset is asserted, and after reset until the first frame pulse is sampled, the serial output is low.
- R2: Each serial output bit equals the control bit that the read port returned on the clock edge before it, so a stored 1 is sent high and a stored 0 is sent low.
- R3: After synchronisation the transmitted position advances by one on every clock and wraps from 255 to 0, giving 256 positions per frame.
- R4: The cycle after an edge that samples the frame pulse high is stream slot 0, and it carries position 8. In general slot s carries position (s + 8) mod 256, so position 0 is sent in slot 248 (channel 31, bit 7).
- R5: The read address is 8 whenever the frame pulse is high. Otherwise, once synchronised, it is the position currently on the output plus one, modulo 256.
- R6: Position index is stream*32 + channel. Position 32 (stream 1, channel 0) is sent in slot 24.
- R7: A change to a stored control bit is first sent the next time that position comes round, and it does not disturb the bit already on the output.
- R8: A frame pulse at any slot, including in mid-frame, restarts the sequence so that the following cycle carries position 8.
- R9: Without further frame pulses the output keeps repeating the 256-position sequence with the same alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Frame marker; the cycle after the edge that samples it is slot 0 |
| ctl_rd_addr | output | 8 | Position whose control bit is read this cycle |
| ctl_rd_bit | input | 1 | Control bit at `ctl_rd_addr`, combinational read |
| ctl_serial_out | output | 1 | Serial per-channel control output |

## Verification
The assertions check on every cycle the position counter's step, wrap and preload, the fetch address, and the rule that the output repeats the bit read one edge earlier. They also check that the output stays low before synchronisation. What the assertions cannot show is the relation between a stored bit and the stream slot where it appears. Only the bench's scenarios show this: whole frames compared slot by slot against the slot-plus-eight mapping, the stream/channel indexing at position 32, a store update landing in the following frame, and realignment by a mid-frame pulse.

// File: rtl/cso_pkg.sv
package cso_pkg;

  // Modular increment used for the position ring.
  function automatic int unsigned ring_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned n);
    return (a + b) % n;
  endfunction

  // Flat position number of a (stream, channel) pair.
  function automatic int unsigned flat_pos(input int unsigned stream,
                                           input int unsigned chan,
                                           input int unsigned chans_per_stream);
    return stream * chans_per_stream + chan;
  endfunction

  // Position carried in a given stream slot, advanced by one channel.
  function automatic int unsigned slot_to_pos(input int unsigned slot,
                                              input int unsigned advance,
                                              input int unsigned n);
    return (slot + advance) % n;
  endfunction

endpackage

// File: rtl/cso_pos_counter.sv
module cso_pos_counter #(
  parameter int unsigned NUM_POS = 256,
  parameter int unsigned ADVANCE = 8,
  localparam int unsigned POS_W  = $clog2(NUM_POS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  output logic [POS_W-1:0] pos_q,
  output logic             locked_q,
  output logic [POS_W-1:0] fetch_addr
);
  import cso_pkg::*;

  localparam logic [POS_W-1:0] PRELOAD = POS_W'(slot_to_pos(0, ADVANCE, NUM_POS));

  logic [POS_W-1:0] next_pos;

  always_comb begin
    next_pos   = POS_W'(ring_add(int'(pos_q), 1, NUM_POS));
    fetch_addr = frame_pulse ? PRELOAD : next_pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else if (frame_pulse) begin
      pos_q    <= PRELOAD;
      locked_q <= 1'b1;
    end else if (locked_q) begin
      pos_q    <= next_pos;
    end
  end

endmodule

// File: rtl/cso_out_reg.sv
module cso_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic bit_in,
  output logic bit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= load_en ? bit_in : 1'b0;
  end
endmodule

// File: rtl/cso_serializer.sv
module cso_serializer #(
  parameter int unsigned STREAMS       = 8,
  parameter int unsigned CHANS_PER_STR = 32,
  parameter int unsigned BITS_PER_CHAN = 8,
  localparam int unsigned NUM_POS      = STREAMS * CHANS_PER_STR,
  localparam int unsigned POS_W        = $clog2(NUM_POS),
  localparam int unsigned ADVANCE      = BITS_PER_CHAN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  output logic [POS_W-1:0] ctl_rd_addr,
  input  logic             ctl_rd_bit,
  output logic             ctl_serial_out
);

  logic [POS_W-1:0] pos_q;
  logic             locked_q;
  logic             load_en;

  cso_pos_counter #(.NUM_POS(NUM_POS), .ADVANCE(ADVANCE)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_pulse(frame_pulse),
    .pos_q      (pos_q),
    .locked_q   (locked_q),
    .fetch_addr (ctl_rd_addr)
  );

  assign load_en = frame_pulse | locked_q;

  cso_out_reg u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_en(load_en),
    .bit_in (ctl_rd_bit),
    .bit_q  (ctl_serial_out)
  );

endmodule

// File: rtl/cso_serializer_chk.sv
module cso_serializer_chk #(
  parameter int unsigned NUM_POS = 256,
  parameter int unsigned ADVANCE = 8,
  localparam int unsigned POS_W  = $clog2(NUM_POS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_pulse,
  input logic [POS_W-1:0] ctl_rd_addr,
  input logic             ctl_rd_bit,
  input logic             ctl_serial_out,
  input logic [POS_W-1:0] pos_q,
  input logic             locked_q
);

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && !frame_pulse) |=> (ctl_serial_out == 1'b0));

  p_bit_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q || frame_pulse) |=> (ctl_serial_out == $past(ctl_rd_bit)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !frame_pulse) |=>
      (int'(pos_q) == (int'($past(pos_q)) + 1) % int'(NUM_POS)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !frame_pulse && int'(pos_q) == int'(NUM_POS) - 1) |=> (pos_q == '0));

  p_preload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> (locked_q && int'(pos_q) == int'(ADVANCE % NUM_POS)));

  p_fetch_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (int'(ctl_rd_addr) == int'(ADVANCE % NUM_POS)));

  p_fetch_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !frame_pulse) |->
      (int'(ctl_rd_addr) == (int'(pos_q) + 1) % int'(NUM_POS)));

endmodule

bind cso_serializer cso_serializer_chk #(.NUM_POS(NUM_POS), .ADVANCE(ADVANCE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_pulse   (frame_pulse),
  .ctl_rd_addr   (ctl_rd_addr),
  .ctl_rd_bit    (ctl_rd_bit),
  .ctl_serial_out(ctl_serial_out),
  .pos_q         (pos_q),
  .locked_q      (locked_q)
);

// File: tb/cso_serializer_tb.sv
module cso_serializer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic [7:0] rd_addr;
  logic       rd_bit;
  logic       sout;
  logic [255:0] ctl_mem = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign rd_bit = ctl_mem[rd_addr];

  cso_serializer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_pulse   (frame_pulse),
    .ctl_rd_addr   (rd_addr),
    .ctl_rd_bit    (rd_bit),
    .ctl_serial_out(sout)
  );

  // Stimulus/expectation table: slot after frame pulse -> position sent there.
  localparam int NV = 8;
  localparam int SLOT_V [NV] = '{0, 7, 23, 24, 247, 248, 249, 255};
  localparam int POS_V  [NV] = '{8, 15, 31, 32, 255, 0, 1, 7};

  // Position expected in a slot: one channel (8 bits) ahead.
  function automatic int exp_pos(input int slot);
    return (slot < 248) ? slot + 8 : slot - 248;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse the frame marker; on return the output shows slot 0.
  task automatic pulse_fp();
    frame_pulse = 1'b1;
    #0;
    check("R5 fetch addr at pulse", int'(rd_addr), 8);
    tick();
    frame_pulse = 1'b0;
  endtask

  function automatic void load_pattern(input int kind);
    for (int p = 0; p < 256; p++) begin
      case (kind)
        0: ctl_mem[p] = ((p * 5 + 3) >> 2) % 2 == 1;
        1: ctl_mem[p] = 1'b1;
        default: ctl_mem[p] = (p % 2) == 1;
      endcase
    end
  endfunction

  // Compare one whole frame, starting at slot 0 (current cycle).
  task automatic check_frame(input string req);
    int bad = 0;
    int first_act = 0;
    int first_exp = 0;
    for (int s = 0; s < 256; s++) begin
      if (s > 0) tick();
      if (sout !== ctl_mem[exp_pos(s)]) begin
        if (bad == 0) begin
          first_act = int'(sout);
          first_exp = int'(ctl_mem[exp_pos(s)]);
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s mismatches=%0d first actual=%0d expected=%0d", req, bad, first_act, first_exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int old_bit;
    load_pattern(1);
    repeat (3) tick();
    check("R1 output low in reset", int'(sout), 0);
    rst_n = 1'b1;
    repeat (20) tick();
    check("R1 output low before first pulse", int'(sout), 0);

    // Main function, pattern 0, then free-running second frame.
    load_pattern(0);
    pulse_fp();
    check_frame("R2 R3 frame pattern0");
    tick();
    check_frame("R9 free-running frame");

    // Table walk: slot to position mapping.
    for (int i = 0; i < NV; i++) begin
      pulse_fp();
      repeat (SLOT_V[i]) tick();
      check($sformatf("R4 R6 slot %0d pos %0d", SLOT_V[i], POS_V[i]),
            int'(sout), int'(ctl_mem[POS_V[i]]));
    end

    // Distinct position 0 / 32 markers (R4, R6).
    ctl_mem = '0;
    ctl_mem[0] = 1'b1;
    ctl_mem[32] = 1'b1;
    pulse_fp();
    repeat (24) tick();
    check("R6 stream1 ch0 in slot 24", int'(sout), 1);
    tick();
    check("R6 slot 25 low", int'(sout), 0);
    repeat (223) tick();
    check("R4 position 0 in slot 248", int'(sout), 1);

    load_pattern(1);
    pulse_fp();
    check_frame("R2 frame all ones");
    load_pattern(2);
    pulse_fp();
    check_frame("R2 frame alternating");

    // Fetch address during running (R5).
    pulse_fp();
    repeat (5) tick();
    check("R5 fetch addr slot 5", int'(rd_addr), 14);
    repeat (242) tick();
    check("R5 fetch addr wraps at slot 247", int'(rd_addr), 0);

    // Store update takes effect next time round (R7).
    load_pattern(0);
    pulse_fp();
    repeat (100) tick();
    old_bit = int'(ctl_mem[40]);
    ctl_mem[40] = ~ctl_mem[40];
    check("R7 current bit undisturbed", int'(sout), int'(ctl_mem[108]));
    repeat (156) tick();
    repeat (32) tick();
    check("R7 updated bit sent next frame", int'(sout), 1 - old_bit);

    // Mid-frame realignment (R8).
    ctl_mem = '0;
    ctl_mem[8] = 1'b1;
    pulse_fp();
    repeat (77) tick();
    check("R8 before realign", int'(sout), 0);
    pulse_fp();
    check("R8 realigned to position 8", int'(sout), 1);
    tick();
    check("R8 next is position 9", int'(sout), 0);

    // Reset during operation (R1).
    ctl_mem = '1;
    pulse_fp();
    rst_n = 1'b0;
    #1;
    check("R1 output low on reset", int'(sout), 0);
    tick();
    rst_n = 1'b1;
    repeat (5) tick();
    check("R1 low again until pulse", int'(sout), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule